// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the burst engine on the device side of a synchronous DRAM. It accepts commands that have already been decoded (READ, WRITE, burst STOP, or nothing), each with a starting column. For every cycle of a burst it produces the column address that the storage array must access. It also marks whether that access is a read or a write. Read data coming back from the array passes through a delay line, so it reaches the data bus exactly one CAS latency after its access cycle. The block drives the output enable of the bus to match.

Three mode settings control the burst. The length can be 1, 2, 4 or 8 beats, or a full page. The ordering can be sequential or interleaved. The CAS latency can be 1 to 3 cycles. A new READ or WRITE always cuts off any burst in progress, and the new burst runs for its full length from its own column. A STOP ends a full-page burst. In any other mode, a STOP has no effect on the burst and only raises an error pulse. Write data arriving outside a write burst never reaches the array.

Top module: `sdram_burst_seq`

## Requirements
- R1: After a synchronous active-low reset, no column access is made, `dq_oe` and `illegal_stop` are low and `dq_out` is zero. Command codes on `cmd` are: 0 NOP, 1 READ, 2 WRITE, 3 STOP.
- R2: Burst length codes on `mode_bl` are: 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8, and 7 for full page. With `mode_il` low, beat k of a burst of length L accesses base + ((s mod L + k) mod L), where s is the start column and base = s - (s mod L). The burst therefore wraps inside its aligned block, and length 1 makes a single access.
- R3: With `mode_il` high and a length of 2, 4 or 8, beat k accesses the start column XOR k.
- R4: In full-page mode, beats are always sequential and wrap from column 511 to column 0. The burst continues until a STOP, READ or WRITE arrives.
- R5: Read data accessed in cycle c appears on `dq_out` with `dq_oe` high in cycle c + `mode_cl`. In every other cycle `dq_oe` is low.
- R6: A READ during a read burst starts a new burst of the full length from the new column in that same cycle. Data from the earlier burst stays on the bus until the new data arrives.
- R7: A WRITE accesses its start column in its own cycle with `arr_wr_data` equal to `dq_in`. The following beats write `dq_in` in each cycle. After the last beat, `col_wr` stays low whatever is on `dq_in`.
- R8: A WRITE during a write burst restarts the burst at the new column for the full programmed length.
- R9: A READ during a write burst makes a read access in its own cycle, and no further write beats follow.
- R10: From the cycle a WRITE is issued, and in every cycle after a write access, `dq_oe` is low. Read data already in the pipeline is discarded.
- R11: A STOP in full-page mode ends the burst: no access is made in the STOP cycle or afterwards, and `dq_oe` falls in cycle STOP + `mode_cl`.
- R12: A STOP in any mode other than full page raises `illegal_stop` for exactly the following cycle and leaves the burst running unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | Decoded command: 0 NOP, 1 READ, 2 WRITE, 3 STOP |
| cmd_col | input | 9 | Start column for READ or WRITE |
| mode_bl | input | 3 | Burst length code |
| mode_il | input | 1 | 1 selects interleaved ordering |
| mode_cl | input | 2 | CAS latency in cycles (1 to 3) |
| dq_in | input | 8 | Write data from the bus |
| arr_rd_data | input | 8 | Array read data for `col_addr`, same cycle |
| col_addr | output | 9 | Column accessed this cycle |
| col_rd | output | 1 | Read access this cycle |
| col_wr | output | 1 | Write access this cycle |
| arr_wr_data | output | 8 | Data to write at `col_addr` |
| dq_out | output | 8 | Read data to the bus |
| dq_oe | output | 1 | Bus output enable |
| illegal_stop | output | 1 | Pulse after a STOP outside full-page mode |

## Verification
Column address, access strobes and write data are combinational, so they are due in the same cycle as the command that causes them. Read data and `dq_oe` are due exactly `mode_cl` cycles after their access cycle. `illegal_stop` is due one cycle after the STOP. The bench drives each cycle's inputs on the falling edge and samples all outputs shortly after, before the next rising edge. It records the samples by cycle index from the command, so each check reads the exact index at which its result is due. The checks also look at the index just before and just after each window, to catch results that arrive early or late.

// File: rtl/sdram_bseq_pkg.sv
// Package: shared command encoding and mode constants for the burst sequencer.
// Assumes decoding of chip-select/strobe pins happens upstream.
package sdram_bseq_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } bseq_cmd_e;

    localparam logic [2:0] BL_FULL = 3'd7;
endpackage

// File: rtl/bseq_colgen.sv
// Column generator: maps burst start, beat count and block mask to a column.
// Assumes mask is 2^n-1 and cnt < mask+1 in interleaved mode.
module bseq_colgen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             il,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] sum;

    // Sequential: add inside the aligned block; interleave: XOR the beat count.
    always_comb begin
        sum  = start + cnt;
        addr = il ? (start ^ cnt) : ((start & ~mask) | (sum & mask));
    end
endmodule

// File: rtl/bseq_rd_pipe.sv
// Read delay line: carries array data and a valid flag for up to MAX_CL
// cycles, and taps the stage chosen by the CAS latency. A flush clears all
// valid flags (used when a write takes the bus).
module bseq_rd_pipe #(
    parameter int DATA_W = 8,
    parameter int MAX_CL = 3,
    parameter int CL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              flush,
    input  logic [DATA_W-1:0] din,
    input  logic [CL_W-1:0]   cl,
    output logic              vld_o,
    output logic [DATA_W-1:0] dat_o
);
    logic [MAX_CL-1:0] vld;
    logic [DATA_W-1:0] dat [MAX_CL];
    logic [CL_W-1:0]   sel;

    // Shift data and valid flags one stage per cycle; flush kills the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < MAX_CL; i++) dat[i] <= '0;
        end else begin
            vld[0] <= push & ~flush;
            dat[0] <= din;
            for (int i = 1; i < MAX_CL; i++) begin
                vld[i] <= vld[i-1] & ~flush;
                dat[i] <= dat[i-1];
            end
        end
    end

    // Tap select: latency n reads stage n-1, clamped to the legal range.
    always_comb begin
        if (cl == '0)
            sel = '0;
        else if (int'(cl) > MAX_CL)
            sel = CL_W'(MAX_CL - 1);
        else
            sel = cl - 1'b1;
        vld_o = vld[sel];
        dat_o = dat[sel];
    end
endmodule

// File: rtl/bseq_ctrl.sv
// Burst controller: holds the active burst (start, beat count, mask, kind),
// applies the interrupt rules and the stop rule, and selects the column
// for the current cycle. Assumes mode inputs are stable while a command is
// issued; they are latched at READ/WRITE.
module bseq_ctrl
    import sdram_bseq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bseq_cmd_e        cmd,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       mode_bl,
    input  logic             mode_il,
    input  logic [COL_W-1:0] gen_addr,
    output logic [COL_W-1:0] start_q,
    output logic [COL_W-1:0] cnt_q,
    output logic [COL_W-1:0] mask_q,
    output logic             il_q,
    output logic [COL_W-1:0] col_addr,
    output logic             col_rd,
    output logic             col_wr,
    output logic             wr_cmd,
    output logic             illegal_stop
);
    logic             act_q, wr_q, full_q;
    logic [COL_W-1:0] mask_new;
    logic             full_new, is_rd, is_wr, is_stop, stop_ok, cont;

    // Decode burst-length code into a block mask.
    always_comb begin
        mask_new = '0;
        case (mode_bl)
            3'd1:    mask_new = COL_W'(1);
            3'd2:    mask_new = COL_W'(3);
            3'd3:    mask_new = COL_W'(7);
            BL_FULL: mask_new = '1;
            default: mask_new = '0;
        endcase
    end

    // Classify the command and decide this cycle's access.
    always_comb begin
        full_new = (mode_bl == BL_FULL);
        is_rd    = (cmd == CMD_READ);
        is_wr    = (cmd == CMD_WRITE);
        is_stop  = (cmd == CMD_STOP);
        stop_ok  = is_stop && full_new;
        cont     = act_q && !is_rd && !is_wr && !stop_ok;
        col_rd   = is_rd || (cont && !wr_q);
        col_wr   = is_wr || (cont && wr_q);
        col_addr = (is_rd || is_wr) ? cmd_col : gen_addr;
        wr_cmd   = is_wr;
    end

    // Burst state: restart on READ/WRITE, end on legal STOP or last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            wr_q    <= 1'b0;
            full_q  <= 1'b0;
            il_q    <= 1'b0;
            start_q <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
        end else if (is_rd || is_wr) begin
            act_q   <= (mask_new != '0);
            wr_q    <= is_wr;
            full_q  <= full_new;
            il_q    <= mode_il && !full_new;
            start_q <= cmd_col;
            cnt_q   <= COL_W'(1);
            mask_q  <= mask_new;
        end else if (stop_ok) begin
            act_q <= 1'b0;
        end else if (cont) begin
            cnt_q <= cnt_q + 1'b1;
            if (!full_q && cnt_q == mask_q) act_q <= 1'b0;
        end
    end

    // Error pulse one cycle after a STOP outside full-page mode.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_stop <= 1'b0;
        else        illegal_stop <= is_stop && !full_new;
    end

    // R2
    block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !full_q) |-> (((gen_addr ^ start_q) & ~mask_q) == '0));
    // R7
    wr_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |-> (col_wr && !col_rd && col_addr == cmd_col));
    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_rd && col_wr));
    // R11
    stop_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP && mode_bl == BL_FULL) |=> (!act_q));
    // R12
    illegal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP && mode_bl != BL_FULL) |=> illegal_stop);
endmodule

// File: rtl/sdram_burst_seq.sv
// Top: SDRAM burst column sequencer. Combines the burst controller, the
// column generator and the read delay line, and gates the bus enable.
// Assumes the array returns read data for col_addr in the same cycle.
module sdram_burst_seq
    import sdram_bseq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int DATA_W = 8,
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [2:0]        mode_bl,
    input  logic              mode_il,
    input  logic [CL_W-1:0]   mode_cl,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_rd,
    output logic              col_wr,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              illegal_stop
);
    logic [COL_W-1:0]  start_q, cnt_q, mask_q, gen_addr;
    logic              il_q, wr_cmd, pipe_vld;
    logic [DATA_W-1:0] pipe_dat;

    bseq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(bseq_cmd_e'(cmd)), .cmd_col(cmd_col),
        .mode_bl(mode_bl), .mode_il(mode_il), .gen_addr(gen_addr),
        .start_q(start_q), .cnt_q(cnt_q), .mask_q(mask_q), .il_q(il_q),
        .col_addr(col_addr), .col_rd(col_rd), .col_wr(col_wr),
        .wr_cmd(wr_cmd), .illegal_stop(illegal_stop)
    );

    bseq_colgen #(.COL_W(COL_W)) u_colgen (
        .start(start_q), .cnt(cnt_q), .mask(mask_q), .il(il_q), .addr(gen_addr)
    );

    bseq_rd_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL), .CL_W(CL_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .push(col_rd), .flush(wr_cmd),
        .din(arr_rd_data), .cl(mode_cl), .vld_o(pipe_vld), .dat_o(pipe_dat)
    );

    // Bus side: write data passes through; output enable yields to writes.
    always_comb begin
        arr_wr_data = dq_in;
        dq_oe       = pipe_vld && !col_wr;
        dq_out      = dq_oe ? pipe_dat : '0;
    end

    // R10
    wr_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_wr |=> !dq_oe);
endmodule

// File: tb/sim_sdram_burst_seq.sv
`timescale 1ns/100ps
module sim_sdram_burst_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic [8:0] cmd_col = '0;
    logic [2:0] mode_bl = 3'd0;
    logic       mode_il = 1'b0;
    logic [1:0] mode_cl = 2'd2;
    logic [7:0] dq_in = '0;
    logic [7:0] arr_rd_data;
    logic [8:0] col_addr;
    logic       col_rd, col_wr, dq_oe, illegal_stop;
    logic [7:0] arr_wr_data, dq_out;

    int total = 0;
    int fails = 0;
    int n = 0;
    int oa [64];
    int ord [64];
    int owr [64];
    int ooe [64];
    int odq [64];
    int oill [64];
    int owd [64];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem(input int a);
        return 8'((a & 255) ^ 8'hA5 ^ ((a >> 8) & 1));
    endfunction

    assign arr_rd_data = mem(int'(col_addr));

    sdram_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_col(cmd_col),
        .mode_bl(mode_bl), .mode_il(mode_il), .mode_cl(mode_cl),
        .dq_in(dq_in), .arr_rd_data(arr_rd_data), .col_addr(col_addr),
        .col_rd(col_rd), .col_wr(col_wr), .arr_wr_data(arr_wr_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .illegal_stop(illegal_stop)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int c, input int col, input int d);
        @(negedge clk);
        cmd = 2'(c); cmd_col = 9'(col); dq_in = 8'(d);
        #0.5;
        oa[n] = int'(col_addr); ord[n] = int'(col_rd); owr[n] = int'(col_wr);
        ooe[n] = int'(dq_oe); odq[n] = int'(dq_out); oill[n] = int'(illegal_stop);
        owd[n] = int'(arr_wr_data);
        n++;
    endtask

    task automatic setup(input int blc, input bit il, input int cl);
        mode_bl = 3'(blc); mode_il = il; mode_cl = 2'(cl);
        repeat (6) step(0, 0, 0);
        n = 0;
    endtask

    function automatic int blen(input int blc);
        return (blc == 0) ? 1 : (blc == 1) ? 2 : (blc == 2) ? 4 : 8;
    endfunction

    function automatic int eaddr(input int s, input int k, input int len, input bit il);
        if (il) return s ^ k;
        return (s - (s % len)) + ((s % len) + k) % len;
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step(0, 0, 0);
        rst_n = 1'b1;
        n = 0;
        step(0, 0, 0);
        chk("R1", "col_rd", ord[0], 0);
        chk("R1", "col_wr", owr[0], 0);
        chk("R1", "dq_oe", ooe[0], 0);
        chk("R1", "illegal_stop", oill[0], 0);
        chk("R1", "dq_out", odq[0], 0);
    endtask

    // R2 R3 R5: plain read burst
    task automatic t_read(input int s, input int blc, input bit il, input int cl, input string req);
        int len;
        len = blen(blc);
        setup(blc, il, cl);
        step(1, s, 0);
        repeat (len + cl + 1) step(0, 0, 0);
        for (int k = 0; k < len; k++) begin
            chk(req, "addr", oa[k], eaddr(s, k, len, il));
            chk(req, "col_rd", ord[k], 1);
        end
        chk(req, "col_rd after burst", ord[len], 0);
        chk("R5", "dq_oe early", ooe[cl-1], 0);
        for (int k = 0; k < len; k++) begin
            chk("R5", "dq_oe", ooe[k+cl], 1);
            chk("R5", "dq_out", odq[k+cl], int'(mem(eaddr(s, k, len, il))));
        end
        chk("R5", "dq_oe after", ooe[len+cl], 0);
    endtask

    // R6: read interrupts read
    task automatic t_rd_rd();
        int ea [6];
        ea = '{8, 9, 20, 21, 22, 23};
        setup(2, 1'b0, 2);
        step(1, 8, 0); step(0, 0, 0); step(1, 20, 0);
        repeat (7) step(0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            chk("R6", "addr", oa[k], ea[k]);
            chk("R6", "col_rd", ord[k], 1);
            chk("R6", "dq_out", odq[k+2], int'(mem(ea[k])));
            chk("R6", "dq_oe", ooe[k+2], 1);
        end
        chk("R6", "col_rd end", ord[6], 0);
        chk("R6", "dq_oe end", ooe[8], 0);
    endtask

    // R7 R8: write interrupts write, then trailing data ignored
    task automatic t_wr_wr();
        int ea [6];
        ea = '{0, 1, 40, 41, 42, 43};
        setup(2, 1'b0, 2);
        step(2, 0, 16); step(0, 0, 17); step(2, 40, 18);
        for (int k = 3; k < 9; k++) step(0, 0, 16 + k);
        for (int k = 0; k < 6; k++) begin
            chk("R8", "addr", oa[k], ea[k]);
            chk("R7", "col_wr", owr[k], 1);
            chk("R7", "wr data", owd[k], 16 + k);
        end
        chk("R7", "late data ignored", owr[6], 0);
        chk("R7", "late data ignored +1", owr[7], 0);
    endtask

    // R9: read interrupts write
    task automatic t_wr_rd();
        int ea [4];
        ea = '{30, 31, 28, 29};
        setup(2, 1'b0, 2);
        step(2, 16, 1); step(1, 30, 2);
        repeat (6) step(0, 0, 3);
        chk("R9", "first write", owr[0], 1);
        chk("R9", "first addr", oa[0], 16);
        for (int k = 0; k < 4; k++) begin
            chk("R9", "col_wr off", owr[k+1], 0);
            chk("R9", "rd addr", oa[k+1], ea[k]);
            chk("R9", "col_rd", ord[k+1], 1);
        end
        chk("R9", "read data", odq[3], int'(mem(30)));
        chk("R9", "no extra", ord[5], 0);
    endtask

    // R10: write interrupts read
    task automatic t_rd_wr();
        int ea [4];
        ea = '{50, 51, 48, 49};
        setup(2, 1'b0, 2);
        step(1, 0, 0); step(0, 0, 0); step(2, 50, 9);
        repeat (6) step(0, 0, 9);
        for (int k = 0; k < 4; k++) begin
            chk("R10", "wr addr", oa[k+2], ea[k]);
            chk("R10", "col_wr", owr[k+2], 1);
        end
        for (int k = 2; k < 8; k++) chk("R10", "dq_oe", ooe[k], 0);
        chk("R10", "write end", owr[6], 0);
    endtask

    // R4 R11: full-page read with wrap, then stop
    task automatic t_full_rd();
        int ea [5];
        ea = '{510, 511, 0, 1, 2};
        setup(7, 1'b1, 3);
        step(1, 510, 0);
        repeat (4) step(0, 0, 0);
        step(3, 0, 0);
        repeat (5) step(0, 0, 0);
        for (int k = 0; k < 5; k++) begin
            chk("R4", "addr", oa[k], ea[k]);
            chk("R4", "col_rd", ord[k], 1);
            chk("R4", "dq_out", odq[k+3], int'(mem(ea[k])));
        end
        chk("R11", "no access at stop", ord[5], 0);
        chk("R11", "no access after", ord[6], 0);
        chk("R11", "dq_oe last", ooe[7], 1);
        chk("R11", "dq_oe off", ooe[8], 0);
        chk("R11", "no error", oill[6], 0);
    endtask

    // R11: full-page write stop
    task automatic t_full_wr();
        setup(7, 1'b0, 2);
        step(2, 100, 1); step(0, 0, 2); step(0, 0, 3); step(3, 0, 4);
        repeat (2) step(0, 0, 5);
        chk("R11", "wr addr", oa[2], 102);
        chk("R11", "col_wr before stop", owr[2], 1);
        chk("R11", "col_wr at stop", owr[3], 0);
        chk("R11", "col_wr after", owr[4], 0);
    endtask

    // R12: stop outside full page
    task automatic t_bad_stop();
        setup(2, 1'b0, 2);
        step(1, 4, 0); step(3, 0, 0);
        repeat (4) step(0, 0, 0);
        chk("R12", "no error before", oill[1], 0);
        chk("R12", "addr at stop", oa[1], 5);
        chk("R12", "col_rd at stop", ord[1], 1);
        chk("R12", "error pulse", oill[2], 1);
        chk("R12", "addr after", oa[2], 6);
        chk("R12", "addr last", oa[3], 7);
        chk("R12", "pulse ends", oill[3], 0);
        chk("R12", "burst ends", ord[4], 0);
        chk("R12", "data kept", odq[5], int'(mem(7)));
    endtask

    initial begin
        t_reset();
        t_read(6, 2, 1'b0, 2, "R2");
        t_read(13, 3, 1'b0, 3, "R2");
        t_read(3, 1, 1'b0, 3, "R2");
        t_read(300, 0, 1'b0, 2, "R2");
        t_read(5, 3, 1'b1, 3, "R3");
        t_read(2, 2, 1'b1, 1, "R3");
        t_rd_rd();
        t_wr_wr();
        t_wr_rd();
        t_rd_wr();
        t_full_rd();
        t_full_wr();
        t_bad_stop();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule